// File: doc/BRIEF.md
# Local DNA Alignment Scoring Array

This block scores local alignments between short DNA queries and longer reference strings with a linear chain of scoring cells. Each cell holds one query base. The cell computes one row of the local-alignment score matrix, and reference bases move from cell to cell one position per clock. Each cell score carries the row and column where its alignment path began. For every segment the block therefore reports the best score, the cell where that score occurs, and the cell where the path started. A later traceback step then only has to recompute the rectangle between those two points.

A per-element flag splits the chain into independent segments, and each segment holds its own query. In shared mode every segment head takes the reference from lane 0, so several queries are aligned against one reference at the same time. In separate mode the head at element k takes its own reference from lane k. With a single segment, the whole chain aligns one query. Runtime inputs set the match, mismatch and gap values. A `start_i` pulse clears all matrix state before a new alignment.

Top module: `sw_align_array`

## Requirements
- R1: Each cell score is the maximum of 0, diagonal + match (or diagonal − mismatch), up − gap and left − gap. match_i, mism_i and gap_i are unsigned magnitudes.
- R2: Bases are coded A=2'b00, C=2'b01, G=2'b10, T=2'b11, and two bases match only when their codes are equal. A pulse on q_we_i writes query base q_base_i into element q_idx_i.
- R3: When candidates tie, the diagonal wins over up, and up wins over left. A cell whose score is 0, or whose diagonal win starts from a zero-scored predecessor, takes its own coordinates as origin. Any other cell inherits the origin of the predecessor it chose.
- R4: Rows count from 1 at the segment head. Columns count from 1 at the first valid reference base after start_i. Each result gives the end row and column and the origin row and column of the reported best cell.
- R5: The best cell is the one with the highest score. When scores are equal, the smaller end column wins, and then the smaller end row. A segment with no positive score reports 0 in all five fields.
- R6: A segment of L elements pulses res_vld_o at its last element exactly L clock edges after the edge on which its head accepts the reference base marked last. The result fields then hold until the next result or start_i.
- R7: seg_start_i[k]=1 makes element k a segment head, and element 0 is always a head. No score, origin or column crosses into a head from the element before it, so each segment behaves as its own array.
- R8: With shared_ref_i=1, every segment head takes lane 0 of ref_vld_i/ref_base_i/ref_last_i (lane k = bit k, bits 2k+1:2k), and all other lanes are ignored.
- R9: With shared_ref_i=0, the head at element k takes lane k, and lanes of non-head elements are ignored.
- R10: A cycle with the feeding lane's valid low changes no cell state and no result.
- R11: After reset, and after a start_i pulse, res_vld_o is low and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears matrix state and results |
| match_i | input | 4 | Match reward |
| mism_i | input | 4 | Mismatch penalty magnitude |
| gap_i | input | 4 | Linear gap penalty magnitude |
| seg_start_i | input | N_PE | Segment head flags |
| shared_ref_i | input | 1 | 1: all heads use lane 0; 0: head k uses lane k |
| q_we_i | input | 1 | Query base write strobe |
| q_idx_i | input | log2(N_PE) | Element written |
| q_base_i | input | 2 | Query base code |
| ref_vld_i | input | N_PE | Reference valid per lane |
| ref_base_i | input | 2*N_PE | Reference base per lane |
| ref_last_i | input | N_PE | Last reference base per lane |
| res_vld_o | output | N_PE | Result pulse at each segment's last element |
| res_score_o | output | N_PE*SCORE_W | Best score per lane |
| res_end_row_o | output | N_PE*COORD_W | End row of best cell |
| res_end_col_o | output | N_PE*COORD_W | End column of best cell |
| res_org_row_o | output | N_PE*COORD_W | Origin row of best alignment |
| res_org_col_o | output | N_PE*COORD_W | Origin column of best alignment |

## Verification
Origin inheritance and the best-cell tie rule are hard to reach from the ports. They only show up when equal scores appear in different columns and rows, and when paths run through gaps. The stimulus includes repeated short queries that produce equal-score hits. It also includes gapped references and random scoring settings. Separate-mode runs combine segments of unequal length with random idle cycles and random noise on the lanes that must be ignored. This checks that each segment's result appears with its own latency and is not disturbed by the other streams.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int CFG_W = 4;
  typedef enum logic [1:0] {BASE_A = 2'd0, BASE_C = 2'd1, BASE_G = 2'd2, BASE_T = 2'd3} base_e;
  typedef enum logic [1:0] {SRC_DIAG, SRC_UP, SRC_LEFT, SRC_ZERO} src_e;
endpackage

// File: rtl/sw_pe.sv
module sw_pe #(
  parameter int SCORE_W = 8,
  parameter int COORD_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      is_head_i,
  input  logic [1:0]                q_base_i,
  input  logic [COORD_W-1:0]        row_i,
  input  logic [sw_pkg::CFG_W-1:0]  match_i,
  input  logic [sw_pkg::CFG_W-1:0]  mism_i,
  input  logic [sw_pkg::CFG_W-1:0]  gap_i,
  input  logic                      in_vld_i,
  input  logic                      in_last_i,
  input  logic [1:0]                in_base_i,
  input  logic [COORD_W-1:0]        in_col_i,
  input  logic [SCORE_W-1:0]        in_h_i,
  input  logic [COORD_W-1:0]        in_or_i,
  input  logic [COORD_W-1:0]        in_oc_i,
  output logic                      cell_vld_o,
  output logic [SCORE_W-1:0]        cell_h_o,
  output logic [COORD_W-1:0]        cell_col_o,
  output logic [COORD_W-1:0]        cell_or_o,
  output logic [COORD_W-1:0]        cell_oc_o,
  output logic                      out_vld_o,
  output logic                      out_last_o,
  output logic [1:0]                out_base_o,
  output logic [COORD_W-1:0]        out_col_o,
  output logic [SCORE_W-1:0]        out_h_o,
  output logic [COORD_W-1:0]        out_or_o,
  output logic [COORD_W-1:0]        out_oc_o
);
  import sw_pkg::*;
  localparam int EW = SCORE_W + 2;
  localparam int PW = EW - CFG_W;

  logic               vld_q, last_q;
  logic [1:0]         base_q;
  logic [COORD_W-1:0] col_q, or_q, oc_q, cnt_q;
  logic [SCORE_W-1:0] h_q, dg_h_q;
  logic [COORD_W-1:0] dg_or_q, dg_oc_q;

  logic [COORD_W-1:0] cur_col;
  logic [SCORE_W-1:0] up_h, dg_h;
  logic signed [EW-1:0] sub, cd, cu, cl, pick;
  src_e               src;
  logic [SCORE_W-1:0] h_n;
  logic [COORD_W-1:0] or_n, oc_n;

  assign cur_col = is_head_i ? cnt_q + COORD_W'(1) : in_col_i;
  assign up_h    = is_head_i ? '0 : in_h_i;
  assign dg_h    = is_head_i ? '0 : dg_h_q;

  always_comb begin
    sub  = (q_base_i == in_base_i) ? $signed({{PW{1'b0}}, match_i})
                                   : -$signed({{PW{1'b0}}, mism_i});
    cd   = $signed({2'b00, dg_h}) + sub;
    cu   = $signed({2'b00, up_h}) - $signed({{PW{1'b0}}, gap_i});
    cl   = $signed({2'b00, h_q})  - $signed({{PW{1'b0}}, gap_i});
    pick = cd;
    src  = SRC_DIAG;
    if (cu > pick) begin pick = cu; src = SRC_UP;   end
    if (cl > pick) begin pick = cl; src = SRC_LEFT; end
    if (pick <= 0) src = SRC_ZERO;
    h_n  = pick[SCORE_W-1:0];
    or_n = row_i;
    oc_n = cur_col;
    unique case (src)
      SRC_ZERO: h_n = '0;
      SRC_DIAG: if (dg_h != '0) begin or_n = dg_or_q; oc_n = dg_oc_q; end
      SRC_UP:   begin or_n = in_or_i; oc_n = in_oc_i; end
      SRC_LEFT: begin or_n = or_q;    oc_n = oc_q;    end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0; last_q <= 1'b0; base_q <= '0; col_q <= '0; h_q <= '0;
      or_q <= '0; oc_q <= '0; cnt_q <= '0; dg_h_q <= '0; dg_or_q <= '0; dg_oc_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0; last_q <= 1'b0; base_q <= '0; col_q <= '0; h_q <= '0;
      or_q <= '0; oc_q <= '0; cnt_q <= '0; dg_h_q <= '0; dg_or_q <= '0; dg_oc_q <= '0;
    end else begin
      vld_q  <= in_vld_i;
      last_q <= in_vld_i & in_last_i;
      if (in_vld_i) begin
        base_q  <= in_base_i;
        col_q   <= cur_col;
        h_q     <= h_n;
        or_q    <= or_n;
        oc_q    <= oc_n;
        dg_h_q  <= up_h;
        dg_or_q <= in_or_i;
        dg_oc_q <= in_oc_i;
        if (is_head_i) cnt_q <= cnt_q + COORD_W'(1);
      end
    end
  end

  assign cell_vld_o = in_vld_i;
  assign cell_h_o   = h_n;
  assign cell_col_o = cur_col;
  assign cell_or_o  = or_n;
  assign cell_oc_o  = oc_n;
  assign out_vld_o  = vld_q;
  assign out_last_o = last_q;
  assign out_base_o = base_q;
  assign out_col_o  = col_q;
  assign out_h_o    = h_q;
  assign out_or_o   = or_q;
  assign out_oc_o   = oc_q;

  p_zero_origin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && h_q == '0) |-> (or_q == row_i && oc_q == col_q));
  p_origin_le_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (or_q <= row_i && oc_q <= col_q && or_q != '0 && oc_q != '0));
  p_head_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && is_head_i) |-> (h_q <= SCORE_W'(match_i)));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_vld_i && !clr_i) |=> ($stable(h_q) && $stable(col_q) && !vld_q));
endmodule

// File: rtl/sw_best.sv
module sw_best #(
  parameter int SCORE_W = 8,
  parameter int COORD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               vld_i,
  input  logic [SCORE_W-1:0] h_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] or_i,
  input  logic [COORD_W-1:0] oc_i,
  output logic [SCORE_W-1:0] best_h_o,
  output logic [COORD_W-1:0] best_er_o,
  output logic [COORD_W-1:0] best_ec_o,
  output logic [COORD_W-1:0] best_or_o,
  output logic [COORD_W-1:0] best_oc_o
);
  // strict compare keeps the earliest column within this row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_h_o <= '0; best_er_o <= '0; best_ec_o <= '0; best_or_o <= '0; best_oc_o <= '0;
    end else if (clr_i) begin
      best_h_o <= '0; best_er_o <= '0; best_ec_o <= '0; best_or_o <= '0; best_oc_o <= '0;
    end else if (vld_i && h_i > best_h_o) begin
      best_h_o  <= h_i;
      best_er_o <= row_i;
      best_ec_o <= col_i;
      best_or_o <= or_i;
      best_oc_o <= oc_i;
    end
  end

  p_best_mono_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (best_h_o >= $past(best_h_o)));
endmodule

// File: rtl/sw_merge.sv
module sw_merge #(
  parameter int N_PE    = 8,
  parameter int SCORE_W = 8,
  parameter int COORD_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clr_i,
  input  logic [N_PE-1:0]                  is_head_i,
  input  logic [N_PE-1:0]                  done_i,
  input  logic [N_PE-1:0][SCORE_W-1:0]     b_h_i,
  input  logic [N_PE-1:0][COORD_W-1:0]     b_er_i,
  input  logic [N_PE-1:0][COORD_W-1:0]     b_ec_i,
  input  logic [N_PE-1:0][COORD_W-1:0]     b_or_i,
  input  logic [N_PE-1:0][COORD_W-1:0]     b_oc_i,
  output logic [N_PE-1:0]                  res_vld_o,
  output logic [N_PE-1:0][SCORE_W-1:0]     res_h_o,
  output logic [N_PE-1:0][COORD_W-1:0]     res_er_o,
  output logic [N_PE-1:0][COORD_W-1:0]     res_ec_o,
  output logic [N_PE-1:0][COORD_W-1:0]     res_or_o,
  output logic [N_PE-1:0][COORD_W-1:0]     res_oc_o
);
  logic [N_PE-1:0][SCORE_W-1:0] acc_h;
  logic [N_PE-1:0][COORD_W-1:0] acc_er, acc_ec, acc_or, acc_oc;
  logic [N_PE-1:0]              seg_end;

  for (genvar j = 0; j < N_PE; j++) begin : g_chain
    assign seg_end[j] = is_head_i[(j + 1) % N_PE];
    if (j == 0) begin : g_first
      assign acc_h[j]  = b_h_i[j];
      assign acc_er[j] = b_er_i[j];
      assign acc_ec[j] = b_ec_i[j];
      assign acc_or[j] = b_or_i[j];
      assign acc_oc[j] = b_oc_i[j];
    end else begin : g_next
      logic take;
      // on equal score and column the earlier (lower) row is kept
      assign take = is_head_i[j] || (b_h_i[j] > acc_h[j-1]) ||
                    (b_h_i[j] == acc_h[j-1] && b_ec_i[j] < acc_ec[j-1]);
      assign acc_h[j]  = take ? b_h_i[j]  : acc_h[j-1];
      assign acc_er[j] = take ? b_er_i[j] : acc_er[j-1];
      assign acc_ec[j] = take ? b_ec_i[j] : acc_ec[j-1];
      assign acc_or[j] = take ? b_or_i[j] : acc_or[j-1];
      assign acc_oc[j] = take ? b_oc_i[j] : acc_oc[j-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_vld_o[j] <= 1'b0;
        res_h_o[j] <= '0; res_er_o[j] <= '0; res_ec_o[j] <= '0; res_or_o[j] <= '0; res_oc_o[j] <= '0;
      end else if (clr_i) begin
        res_vld_o[j] <= 1'b0;
        res_h_o[j] <= '0; res_er_o[j] <= '0; res_ec_o[j] <= '0; res_or_o[j] <= '0; res_oc_o[j] <= '0;
      end else begin
        res_vld_o[j] <= seg_end[j] & done_i[j];
        if (seg_end[j] && done_i[j]) begin
          res_h_o[j]  <= acc_h[j];
          res_er_o[j] <= acc_er[j];
          res_ec_o[j] <= acc_ec[j];
          res_or_o[j] <= acc_or[j];
          res_oc_o[j] <= acc_oc[j];
        end
      end
    end

    p_res_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_vld_o[j] |-> $past(seg_end[j]));
  end
endmodule

// File: rtl/sw_align_array.sv
module sw_align_array #(
  parameter int N_PE    = 8,
  parameter int SCORE_W = 8,
  parameter int COORD_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [sw_pkg::CFG_W-1:0]    match_i,
  input  logic [sw_pkg::CFG_W-1:0]    mism_i,
  input  logic [sw_pkg::CFG_W-1:0]    gap_i,
  input  logic [N_PE-1:0]             seg_start_i,
  input  logic                        shared_ref_i,
  input  logic                        q_we_i,
  input  logic [$clog2(N_PE)-1:0]     q_idx_i,
  input  logic [1:0]                  q_base_i,
  input  logic [N_PE-1:0]             ref_vld_i,
  input  logic [2*N_PE-1:0]           ref_base_i,
  input  logic [N_PE-1:0]             ref_last_i,
  output logic [N_PE-1:0]             res_vld_o,
  output logic [N_PE*SCORE_W-1:0]     res_score_o,
  output logic [N_PE*COORD_W-1:0]     res_end_row_o,
  output logic [N_PE*COORD_W-1:0]     res_end_col_o,
  output logic [N_PE*COORD_W-1:0]     res_org_row_o,
  output logic [N_PE*COORD_W-1:0]     res_org_col_o
);
  localparam int IDX_W = $clog2(N_PE);

  logic [N_PE-1:0][1:0]         qry_q;
  logic [N_PE-1:0]              is_head;
  logic [N_PE-1:0][COORD_W-1:0] row;

  logic [N_PE-1:0]              in_vld, in_last;
  logic [N_PE-1:0][1:0]         in_base;
  logic [N_PE-1:0][IDX_W-1:0]   lane;

  logic [N_PE-1:0]              c_vld;
  logic [N_PE-1:0][SCORE_W-1:0] c_h;
  logic [N_PE-1:0][COORD_W-1:0] c_col, c_or, c_oc;

  logic [N_PE-1:0]              o_vld, o_last;
  logic [N_PE-1:0][1:0]         o_base;
  logic [N_PE-1:0][SCORE_W-1:0] o_h;
  logic [N_PE-1:0][COORD_W-1:0] o_col, o_or, o_oc;

  logic [N_PE-1:0][SCORE_W-1:0] b_h, r_h;
  logic [N_PE-1:0][COORD_W-1:0] b_er, b_ec, b_or, b_oc, r_er, r_ec, r_or, r_oc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               qry_q <= '0;
    else if (q_we_i && int'(q_idx_i) < N_PE)   qry_q[q_idx_i] <= q_base_i;
  end

  for (genvar j = 0; j < N_PE; j++) begin : g_pe
    localparam int UP = (j + N_PE - 1) % N_PE;

    assign is_head[j] = (j == 0) ? 1'b1 : seg_start_i[j];
    assign lane[j]    = shared_ref_i ? '0 : IDX_W'(j);

    if (j == 0) begin : g_row0
      assign row[j] = COORD_W'(1);
    end else begin : g_rown
      assign row[j] = is_head[j] ? COORD_W'(1) : row[j-1] + COORD_W'(1);
    end

    assign in_vld[j]  = is_head[j] ? ref_vld_i[lane[j]]          : o_vld[UP];
    assign in_last[j] = is_head[j] ? ref_last_i[lane[j]]         : o_last[UP];
    assign in_base[j] = is_head[j] ? ref_base_i[2*lane[j] +: 2]  : o_base[UP];

    sw_pe #(.SCORE_W(SCORE_W), .COORD_W(COORD_W)) u_pe (
      .clk_i, .rst_ni, .clr_i(start_i),
      .is_head_i(is_head[j]), .q_base_i(qry_q[j]), .row_i(row[j]),
      .match_i, .mism_i, .gap_i,
      .in_vld_i(in_vld[j]), .in_last_i(in_last[j]), .in_base_i(in_base[j]),
      .in_col_i(o_col[UP]), .in_h_i(o_h[UP]), .in_or_i(o_or[UP]), .in_oc_i(o_oc[UP]),
      .cell_vld_o(c_vld[j]), .cell_h_o(c_h[j]), .cell_col_o(c_col[j]),
      .cell_or_o(c_or[j]), .cell_oc_o(c_oc[j]),
      .out_vld_o(o_vld[j]), .out_last_o(o_last[j]), .out_base_o(o_base[j]),
      .out_col_o(o_col[j]), .out_h_o(o_h[j]), .out_or_o(o_or[j]), .out_oc_o(o_oc[j])
    );

    sw_best #(.SCORE_W(SCORE_W), .COORD_W(COORD_W)) u_best (
      .clk_i, .rst_ni, .clr_i(start_i),
      .vld_i(c_vld[j]), .h_i(c_h[j]), .row_i(row[j]), .col_i(c_col[j]),
      .or_i(c_or[j]), .oc_i(c_oc[j]),
      .best_h_o(b_h[j]), .best_er_o(b_er[j]), .best_ec_o(b_ec[j]),
      .best_or_o(b_or[j]), .best_oc_o(b_oc[j])
    );
  end

  sw_merge #(.N_PE(N_PE), .SCORE_W(SCORE_W), .COORD_W(COORD_W)) u_merge (
    .clk_i, .rst_ni, .clr_i(start_i),
    .is_head_i(is_head), .done_i(o_vld & o_last),
    .b_h_i(b_h), .b_er_i(b_er), .b_ec_i(b_ec), .b_or_i(b_or), .b_oc_i(b_oc),
    .res_vld_o, .res_h_o(r_h), .res_er_o(r_er), .res_ec_o(r_ec),
    .res_or_o(r_or), .res_oc_o(r_oc)
  );

  assign res_score_o   = r_h;
  assign res_end_row_o = r_er;
  assign res_end_col_o = r_ec;
  assign res_org_row_o = r_or;
  assign res_org_col_o = r_oc;

  p_reset_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (res_vld_o == '0 && res_score_o == '0));
endmodule

// File: tb/sw_align_array_test.sv
module sw_align_array_test;
  localparam int N = 8, SW = 8, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] match_r = 4'd2, mism_r = 4'd1, gap_r = 4'd1;
  logic [N-1:0] seg_start = '0;
  logic shared = 1'b1, q_we = 1'b0;
  logic [2:0] q_idx = '0;
  logic [1:0] q_base = '0;
  logic [N-1:0] ref_vld = '0, ref_last = '0;
  logic [2*N-1:0] ref_base = '0;
  logic [N-1:0] res_vld;
  logic [N*SW-1:0] res_score;
  logic [N*CW-1:0] res_er, res_ec, res_or, res_oc;

  always #4 clk = ~clk;

  sw_align_array #(.N_PE(N), .SCORE_W(SW), .COORD_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .match_i(match_r), .mism_i(mism_r), .gap_i(gap_r),
    .seg_start_i(seg_start), .shared_ref_i(shared),
    .q_we_i(q_we), .q_idx_i(q_idx), .q_base_i(q_base),
    .ref_vld_i(ref_vld), .ref_base_i(ref_base), .ref_last_i(ref_last),
    .res_vld_o(res_vld), .res_score_o(res_score),
    .res_end_row_o(res_er), .res_end_col_o(res_ec),
    .res_org_row_o(res_or), .res_org_col_o(res_oc)
  );

  typedef struct {int lane; int req; int s; int er; int ec; int orr; int oc; int cyc;} exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int qry[N];
  int refs[N][64];
  int ref_len[N];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int code(byte ch);  // R2: A=0 C=1 G=2 T=3
    case (ch)
      "A": return 0; "C": return 1; "G": return 2; default: return 3;
    endcase
  endfunction

  task automatic load_q(int at, string s);
    for (int i = 0; i < s.len(); i++) qry[at+i] = code(s[i]);
  endtask

  task automatic load_r(int ln, string s);
    for (int i = 0; i < s.len(); i++) refs[ln][i] = code(s[i]);
    ref_len[ln] = s.len();
  endtask

  // golden local-alignment model: R1, R3, R4, R5
  task automatic calc(input int head, input int ql, input int ln,
                      output int bs, output int ber, output int bec, output int bor, output int boc);
    int h[9][65]; int orr[9][65]; int ocl[9][65];
    int mt, mm, g, m;
    mt = int'(match_r); mm = int'(mism_r); g = int'(gap_r); m = ref_len[ln];
    for (int r = 0; r < 9; r++) for (int c = 0; c < 65; c++) begin h[r][c] = 0; orr[r][c] = 0; ocl[r][c] = 0; end
    bs = 0; ber = 0; bec = 0; bor = 0; boc = 0;
    for (int c = 1; c <= m; c++) begin
      for (int r = 1; r <= ql; r++) begin
        int s, d, u, lf, p, src;
        s  = (qry[head+r-1] == refs[ln][c-1]) ? mt : -mm;
        d  = h[r-1][c-1] + s; u = h[r-1][c] - g; lf = h[r][c-1] - g;
        p = d; src = 0;
        if (u > p)  begin p = u;  src = 1; end
        if (lf > p) begin p = lf; src = 2; end
        if (p <= 0) begin h[r][c] = 0; orr[r][c] = r; ocl[r][c] = c; end
        else begin
          h[r][c] = p;
          if (src == 0) begin
            if (h[r-1][c-1] == 0) begin orr[r][c] = r; ocl[r][c] = c; end
            else begin orr[r][c] = orr[r-1][c-1]; ocl[r][c] = ocl[r-1][c-1]; end
          end else if (src == 1) begin orr[r][c] = orr[r-1][c]; ocl[r][c] = ocl[r-1][c]; end
          else begin orr[r][c] = orr[r][c-1]; ocl[r][c] = ocl[r][c-1]; end
        end
        if (h[r][c] > bs) begin bs = h[r][c]; ber = r; bec = c; bor = orr[r][c]; boc = ocl[r][c]; end
      end
    end
  endtask

  // monitor: pops the matching lane entry, checks fields and latency (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < N; l++) begin
        if (res_vld[l]) begin
          int idx;
          idx = -1;
          for (int i = 0; i < exp_q.size(); i++) if (idx < 0 && exp_q[i].lane == l) idx = i;
          n_chk++;
          if (idx < 0) begin
            n_fail++;
            $display("FAIL R7 lane %0d: unexpected result pulse, expected none", l);
          end else begin
            exp_t e;
            int gs, ge, gc, go, gq;
            e = exp_q[idx];
            exp_q.delete(idx);
            gs = int'(res_score[l*SW +: SW]); ge = int'(res_er[l*CW +: CW]); gc = int'(res_ec[l*CW +: CW]);
            go = int'(res_or[l*CW +: CW]); gq = int'(res_oc[l*CW +: CW]);
            if (gs != e.s || ge != e.er || gc != e.ec || go != e.orr || gq != e.oc || cyc != e.cyc) begin
              n_fail++;
              $display("FAIL R%0d lane %0d: got s=%0d end=(%0d,%0d) org=(%0d,%0d) cyc=%0d exp s=%0d end=(%0d,%0d) org=(%0d,%0d) cyc=%0d",
                       e.req, l, gs, ge, gc, go, gq, cyc, e.s, e.er, e.ec, e.orr, e.oc, e.cyc);
            end
          end
        end
      end
    end
  end

  // driver: loads queries, pulses start, feeds lanes, pushes expectations
  task automatic run_case(input logic [N-1:0] segs, input bit shr, input int req,
                          input bit bubbles, input bit noise);
    int es[N], eer[N], eec[N], eor[N], eoc[N], elen[N], pos[N];
    bit head[N];
    bit done;
    int wait_n;
    @(negedge clk);
    seg_start = segs; shared = shr;
    for (int i = 0; i < N; i++) begin
      q_we = 1'b1; q_idx = 3'(i); q_base = 2'(qry[i]);
      @(negedge clk);
    end
    q_we = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_chk++;  // R11: start clears results
    if (res_vld != '0 || res_score != '0 || res_er != '0 || res_oc != '0) begin
      n_fail++;
      $display("FAIL R11: after start got vld=%h score=%h, expected 0", res_vld, res_score);
    end
    for (int j = 0; j < N; j++) head[j] = (j == 0) || segs[j];
    for (int j = 0; j < N; j++) begin
      pos[j] = 0;
      if (head[j]) begin
        int k;
        k = j + 1;
        while (k < N && !head[k]) k++;
        elen[j] = k - j;
        calc(j, elen[j], shr ? 0 : j, es[j], eer[j], eec[j], eor[j], eoc[j]);
      end
    end
    done = 1'b0;
    while (!done) begin
      done = 1'b1;
      for (int l = 0; l < N; l++) begin
        bit stream;
        stream = shr ? (l == 0) : head[l];
        ref_vld[l] = 1'b0; ref_last[l] = 1'b0; ref_base[2*l +: 2] = 2'b00;
        if (stream && pos[l] < ref_len[l]) begin
          done = 1'b0;
          if (!(bubbles && ($urandom % 4 == 0))) begin
            ref_vld[l] = 1'b1;
            ref_base[2*l +: 2] = 2'(refs[l][pos[l]]);
            ref_last[l] = (pos[l] == ref_len[l] - 1);
            if (ref_last[l]) begin
              for (int j = 0; j < N; j++) begin
                if (head[j] && (shr || j == l)) begin
                  exp_t e;
                  e.lane = j + elen[j] - 1; e.req = req; e.s = es[j]; e.er = eer[j];
                  e.ec = eec[j]; e.orr = eor[j]; e.oc = eoc[j]; e.cyc = cyc + 1 + elen[j];
                  exp_q.push_back(e);
                end
              end
            end
            pos[l]++;
          end
        end else if (!stream && noise) begin
          ref_vld[l] = 1'($urandom); ref_last[l] = 1'($urandom);
          ref_base[2*l +: 2] = 2'($urandom);
        end
      end
      @(negedge clk);
    end
    ref_vld = '0; ref_last = '0; ref_base = '0;
    wait_n = 0;
    while (exp_q.size() != 0 && wait_n < 100) begin @(negedge clk); wait_n++; end
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R6: %0d results missing, expected 0 outstanding", exp_q.size());
      exp_q.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;  // R11: reset state
    if (res_vld != '0 || res_score != '0 || res_er != '0 || res_ec != '0 || res_or != '0 || res_oc != '0) begin
      n_fail++;
      $display("FAIL R11: reset outputs vld=%h score=%h, expected all 0", res_vld, res_score);
    end

    // R1 R2 R4: one segment, default scoring
    load_q(0, "ACGTTGCA");
    load_r(0, "GGACGTAGCATT");
    run_case(8'h01, 1'b1, 1, 1'b0, 1'b0);

    // R10: same query, other scoring, idle gaps in the stream
    match_r = 4'd3; mism_r = 4'd2; gap_r = 4'd2;
    load_r(0, "TACGTTGGCATACGA");
    run_case(8'h01, 1'b1, 10, 1'b1, 1'b0);

    // R3: path through a gap, origin inherited
    match_r = 4'd2; mism_r = 4'd1; gap_r = 4'd1;
    load_q(0, "ACGTACGT");
    load_r(0, "TTACGTCACGTGG");
    run_case(8'h01, 1'b1, 3, 1'b0, 1'b0);

    // R5: no positive score gives all zeros
    load_q(0, "AAAAAAAA");
    load_r(0, "TTTTTTTTTT");
    run_case(8'h01, 1'b1, 5, 1'b0, 1'b0);

    // R7 R8: three segments on one shared stream, noise on ignored lanes
    load_q(0, "ACG"); load_q(3, "GT"); load_q(5, "TAC");
    load_r(0, "CAGTACGGTTACG");
    run_case(8'b0010_1001, 1'b1, 8, 1'b1, 1'b1);

    // R5: equal hits in several columns, two-element segments
    load_q(0, "AC"); load_q(2, "AC"); load_q(4, "CA"); load_q(6, "GG");
    load_r(0, "ACTTACGGCA");
    run_case(8'b0101_0101, 1'b1, 5, 1'b0, 1'b0);

    // R9 R7: separate streams of unequal length, idle gaps, noise
    load_q(0, "GATC"); load_q(4, "CCTA");
    load_r(0, "TGATCAAGT");
    load_r(4, "AACCTAGGCCTATTCC");
    run_case(8'b0001_0001, 1'b0, 9, 1'b1, 1'b1);

    // R9: one-element and longer segments on own lanes
    load_q(0, "T"); load_q(1, "ACGTAGC");
    load_r(0, "GGTAT");
    load_r(1, "CACGTTAGCA");
    run_case(8'b0000_0011, 1'b0, 9, 1'b0, 1'b1);

    // R1: random single-stream cases with random scoring
    for (int t = 0; t < 6; t++) begin
      int ml;
      match_r = 4'(1 + $urandom % 4); mism_r = 4'($urandom % 4); gap_r = 4'($urandom % 4);
      for (int i = 0; i < N; i++) qry[i] = int'($urandom % 4);
      ml = 10 + int'($urandom % 30);
      for (int i = 0; i < ml; i++) refs[0][i] = int'($urandom % 4);
      ref_len[0] = ml;
      run_case(8'h01, 1'b1, 1, t[0], 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule